// File: doc/BRIEF.md
# Signed Sequential Shift-Add Multiplier

This block multiplies two signed operands of `WIDTH` bits, one bit of the multiplier per clock. When a request is accepted, each operand is reduced to its unsigned magnitude. The sign of the result is kept apart as the exclusive-or of the two operand sign bits. The magnitudes then go through a shift-add sequence over three registers: a multiplicand register, an accumulator that starts at zero, and a multiplier register that fills up with the low half of the product. At the end the double-width magnitude is negated if the result sign is set.

A client raises `start` for one cycle while the block is idle, with both operands valid. Exactly `WIDTH` cycles later the block raises `done` for one cycle with the full `2*WIDTH`-bit two's-complement product. The product stays on `product` until the next completion. Requests that arrive while a multiplication is in progress are dropped. A new request may be issued in the same cycle that `done` is high.

Top module: `smul_top`

## Requirements
- R1: While `rst_n` is low, `done` is 0 and `product` is 0.
- R2: When `start` is sampled high while idle, `done` is high for one cycle starting WIDTH clock edges after that sampling edge.
- R3: For two non-negative operands, `product` at `done` equals their unsigned product, zero-extended to 2*WIDTH bits.
- R4: Operands are two's-complement values with the sign in bit WIDTH-1; a negative operand is turned into its magnitude before the iterations.
- R5: The result sign is the XOR of the two operand sign bits. When it is 1, the product is the two's complement of the magnitude product, so a zero product stays 0.
- R6: The most negative operand value (only bit WIDTH-1 set) is handled as magnitude 2^(WIDTH-1) with either sign of the other operand, and the product never wraps.
- R7: `done` is never high on two consecutive cycles.
- R8: `start` while a multiplication is in progress is ignored: the result and the `done` timing of the running request are unchanged, and no extra `done` follows.
- R9: `product` changes only on a cycle in which `done` rises, and it holds its value until the next completion.
- R10: A `start` sampled in the cycle where `done` is high is accepted as a new request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, sampled only while idle |
| mcand | input | WIDTH | Signed multiplicand |
| mplier | input | WIDTH | Signed multiplier |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2*WIDTH | Signed product, held between completions |

## Verification
The hardest cases to reach from the ports are a request that arrives in the middle of a running multiplication and a request that lands exactly on the completion cycle. Both depend on the cycle at which `start` is raised, not on the operand values. The stimulus raises a second `start` a few cycles into a run to check that it is dropped. It also issues the next request in the same cycle that `done` is first seen, to check that it is taken. The most negative operand is driven against each sign of the other operand, and those cases are mixed with a long pseudo-random operand stream, all compared cycle by cycle against a behavioural model.

// File: rtl/smul_pkg.sv
package smul_pkg;
   typedef enum logic [0:0] {
      SM_IDLE = 1'b0,
      SM_RUN  = 1'b1
   } smul_state_e;
endpackage

// File: rtl/smul_cond_neg.sv
module smul_cond_neg #(
   parameter int W = 8
) (
   input  logic [W-1:0] value,
   input  logic         negate,
   output logic [W-1:0] result
);
   logic [W-1:0] flipped;

   for (genvar i = 0; i < W; i++) begin : g_flip
      assign flipped[i] = value[i] ^ negate;
   end

   assign result = flipped + {{(W-1){1'b0}}, negate};
endmodule

// File: rtl/smul_ctrl.sv
module smul_ctrl
   import smul_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic step,
   output logic last,
   output logic done
);
   localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WIDTH - 1);

   smul_state_e      state_q;
   logic [CNT_W-1:0] cnt_q;

   assign load = (state_q == SM_IDLE) && start;
   assign step = (state_q == SM_RUN);
   assign last = step && (cnt_q == LAST_CNT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SM_IDLE;
         cnt_q   <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (load) begin
            state_q <= SM_RUN;
            cnt_q   <= '0;
         end else if (last) begin
            state_q <= SM_IDLE;
            done    <= 1'b1;
         end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/smul_datapath.sv
module smul_datapath #(
   parameter int WIDTH = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               step,
   input  logic               last,
   input  logic [WIDTH-1:0]   mcand_mag,
   input  logic [WIDTH-1:0]   mplier_mag,
   input  logic               sign_in,
   output logic [2*WIDTH-1:0] mag_prod,
   output logic               sign_q
);
   logic [WIDTH-1:0] b_q;
   logic [WIDTH-1:0] acc_q;
   logic [WIDTH-1:0] q_q;
   logic [WIDTH:0]   sum;

   // add the multiplicand when the current multiplier bit is set; carry kept
   assign sum = {1'b0, acc_q} + (q_q[0] ? {1'b0, b_q} : '0);

   // final step skips its shift: bit 0 of Q is already consumed
   assign mag_prod = {sum, q_q[WIDTH-1:1]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         b_q    <= '0;
         acc_q  <= '0;
         q_q    <= '0;
         sign_q <= 1'b0;
      end else if (load) begin
         b_q    <= mcand_mag;
         acc_q  <= '0;
         q_q    <= mplier_mag;
         sign_q <= sign_in;
      end else if (step && !last) begin
         acc_q <= sum[WIDTH:1];
         q_q   <= {sum[0], q_q[WIDTH-1:1]};
      end
   end
endmodule

// File: rtl/smul_top.sv
module smul_top #(
   parameter int WIDTH = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [WIDTH-1:0]   mcand,
   input  logic [WIDTH-1:0]   mplier,
   output logic               done,
   output logic [2*WIDTH-1:0] product
);
   localparam int PW = 2 * WIDTH;

   if (WIDTH < 2) begin : g_width_bad
      $error("smul_top: WIDTH must be at least 2");
   end

   logic             load, step, last, sign_q;
   logic [WIDTH-1:0] mcand_mag, mplier_mag;
   logic [PW-1:0]    mag_prod, signed_prod;

   smul_cond_neg #(.W(WIDTH)) u_abs_a (
      .value(mcand), .negate(mcand[WIDTH-1]), .result(mcand_mag));

   smul_cond_neg #(.W(WIDTH)) u_abs_b (
      .value(mplier), .negate(mplier[WIDTH-1]), .result(mplier_mag));

   smul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .load(load), .step(step), .last(last), .done(done));

   smul_datapath #(.WIDTH(WIDTH)) u_dp (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step), .last(last),
      .mcand_mag(mcand_mag), .mplier_mag(mplier_mag),
      .sign_in(mcand[WIDTH-1] ^ mplier[WIDTH-1]),
      .mag_prod(mag_prod), .sign_q(sign_q));

   smul_cond_neg #(.W(PW)) u_fix_sign (
      .value(mag_prod), .negate(sign_q), .result(signed_prod));

   always_ff @(posedge clk) begin
      if (!rst_n) product <= '0;
      else if (last) product <= signed_prod;
   end
endmodule

// File: rtl/smul_chk.sv
module smul_chk #(
   parameter int WIDTH = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic [WIDTH-1:0]   mcand,
   input logic [WIDTH-1:0]   mplier,
   input logic               done,
   input logic [2*WIDTH-1:0] product
);
   localparam int PW = 2 * WIDTH;

   logic             busy_c;
   int unsigned      cyc_c;
   logic [WIDTH-1:0] cap_a, cap_b;
   logic [PW-1:0]    ref_prod;

   assign ref_prod = $signed({{WIDTH{cap_a[WIDTH-1]}}, cap_a})
                   * $signed({{WIDTH{cap_b[WIDTH-1]}}, cap_b});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_c <= 1'b0;
         cyc_c  <= 0;
         cap_a  <= '0;
         cap_b  <= '0;
      end else if (busy_c) begin
         cyc_c <= cyc_c + 1;
         if (cyc_c + 1 == WIDTH) busy_c <= 1'b0;
      end else if (start) begin
         busy_c <= 1'b1;
         cyc_c  <= 0;
         cap_a  <= mcand;
         cap_b  <= mplier;
      end
   end

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(product));

   // R2
   done_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (!busy_c && cyc_c == WIDTH));

   // R8
   no_stray_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_c && cyc_c + 1 != WIDTH) |=> !done);

   // R5
   product_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> product == ref_prod);
endmodule

bind smul_top smul_chk #(.WIDTH(WIDTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand),
   .mplier(mplier), .done(done), .product(product));

// File: tb/sim_smul_top.sv
module sim_smul_top;
   localparam int W  = 8;
   localparam int PW = 2 * W;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [W-1:0]  mcand = '0, mplier = '0;
   logic          done;
   logic [PW-1:0] product;

   int    n_checks = 0, n_fail = 0, cycles = 0;
   string cur_req = "R1";

   // reference model state
   bit            m_busy = 0, m_done = 0;
   int            m_cnt = 0;
   logic [PW-1:0] m_prod = '0, m_pend = '0;

   always #2.5 clk = ~clk;

   smul_top #(.WIDTH(W)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand),
      .mplier(mplier), .done(done), .product(product));

   function automatic logic [PW-1:0] ref_mul(logic [W-1:0] a, logic [W-1:0] b);
      int r;
      r = int'($signed(a)) * int'($signed(b));
      return r[PW-1:0];
   endfunction

   task automatic check(string req, logic [PW-1:0] act, logic [PW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
      end
   endtask

   task automatic finish_up();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   // behavioural model, advanced on each rising edge
   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_prod = '0;
      end else begin
         m_done = 0;
         if (m_busy) begin
            m_cnt++;
            if (m_cnt == W) begin
               m_done = 1; m_busy = 0; m_prod = m_pend;
            end
         end else if (start) begin
            m_busy = 1; m_cnt = 0; m_pend = ref_mul(mcand, mplier);
         end
      end
      if (cycles > 150000) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired");
         finish_up();
      end
   end

   // compare against the model every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         check("R2 R7 done", {{(PW-1){1'b0}}, done}, {{(PW-1){1'b0}}, m_done});
         check(cur_req, product, m_prod);
      end
   end

   // starts at a negedge, ends at the negedge where done is first seen
   task automatic op(logic [W-1:0] a, logic [W-1:0] b, string req);
      int lat;
      cur_req = req;
      start = 1'b1; mcand = a; mplier = b;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < W + 4) begin
         @(negedge clk);
         lat++;
      end
      check({req, " latency"}, PW'(lat), PW'(W + 1));
      check(req, product, ref_mul(a, b));
   endtask

   initial begin
      logic [15:0] lfsr;
      logic [PW-1:0] held;
      // R1: reset state, start during reset has no effect
      mcand = 8'd3; mplier = 8'd4; start = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 done", {{(PW-1){1'b0}}, done}, '0);
      check("R1 product", product, '0);
      start = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);

      // R3: non-negative operands
      op(8'd5, 8'd7, "R3");
      op(8'd127, 8'd127, "R3");
      op(8'd0, 8'd99, "R3");
      op(8'd1, 8'd1, "R3");
      op(8'd85, 8'd2, "R3");

      // R4 R5: negative operands and sign rule
      op(8'hFD, 8'd5, "R4");
      op(8'd3, 8'hFB, "R5");
      op(8'hFD, 8'hFB, "R4");
      op(8'hFF, 8'hFF, "R4");
      op(8'd0, 8'hF9, "R5 negative zero");
      op(8'hC0, 8'd0, "R5 negative zero");

      // R6: most negative value
      op(8'h80, 8'h80, "R6");
      op(8'h80, 8'd127, "R6");
      op(8'h80, 8'd1, "R6");
      op(8'd127, 8'h80, "R6");
      op(8'h80, 8'hFF, "R6");

      // R9 R7: product holds while idle, done stays low
      repeat (W + 2) @(negedge clk);
      cur_req = "R9";
      check("R9 hold", product, ref_mul(8'h80, 8'hFF));
      check("R7 quiet", {{(PW-1){1'b0}}, done}, '0);

      // R8: second start in mid-run is dropped
      cur_req = "R8";
      start = 1'b1; mcand = 8'd9; mplier = 8'hF3;
      @(negedge clk);
      start = 1'b0;
      repeat (2) @(negedge clk);
      start = 1'b1; mcand = 8'd100; mplier = 8'd100;
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      check("R8 first result kept", product, ref_mul(8'd9, 8'hF3));
      held = product;
      repeat (W + 3) begin
         @(negedge clk);
         check("R8 no extra done", {{(PW-1){1'b0}}, done}, '0);
      end
      check("R9 held after R8", product, held);

      // R10: back-to-back requests issued on the done cycle
      op(8'd11, 8'd13, "R10");
      op(8'hF0, 8'd16, "R10");
      op(8'd77, 8'h81, "R10");

      // pseudo-random stream
      lfsr = 16'hACE1;
      for (int i = 0; i < 300; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         op(lfsr[7:0], lfsr[15:8], "R5 random");
      end

      repeat (3) @(negedge clk);
      finish_up();
   end
endmodule